// File: doc/BRIEF.md
# Mailbox Command Sequencer

This block sends a single 32-bit command into a peripheral that exposes a byte-wide register mailbox. When `start` pulses, the block captures the command word and splits it into four bytes. It stores those bytes in the mailbox data registers and then sets the launch bit. Next it confirms that the peripheral raised its acknowledge flag and polls the peripheral's busy bit until the work is finished. Finally it clears the acknowledge flag by writing a one to that flag's bit position.

Every command follows the same access order. A one-cycle `done` pulse closes each command. `err` rises in that same cycle when the acknowledge flag was missing, or when the busy poll ran past its programmable limit.

The host side is a plain address / write-data / read-data bus with a wait-request input. Only one read or one write is presented at a time.

Top module: `mbox_cmd_seq`

## Requirements
- R1: After `start`, the command word goes out as four full 8-bit writes to byte addresses 0x84, 0x85, 0x86 and 0x87, in that order. Bits [7:0] go to 0x84 and bits [31:24] go to 0x87.
- R2: Right after the fourth data byte, the block writes 0x01 to address 0x90. Bit 0 of that value is the launch bit.
- R3: After the launch write, the block reads address 0x8A. If bit 7 of the returned byte is 0, the command ends with `done` and `err` both high, and no further access is made.
- R4: When bit 7 was 1, the block reads address 0x8B again and again while bit 0 of the returned byte is 1. It stops after the first read that returns bit 0 = 0.
- R5: After the busy bit reads 0, the block writes 0x80 to address 0x8A, which sets bit 7 to clear the flag. The command then ends with `done` high and `err` low.
- R6: `bus_write` and `bus_read` are never both high. While `bus_waitreq` is high, an access keeps its address, data and strobe unchanged. An access is accepted in a cycle where a strobe is high and `bus_waitreq` is low.
- R7: Read data is taken from `bus_rdata` in the cycle that follows acceptance of the read, not in the acceptance cycle itself.
- R8: With a nonzero `poll_limit` of L, suppose L reads of 0x8B return bit 0 = 1. The command then ends with `done` and `err` high, and the acknowledge flag is not cleared. A `poll_limit` of 0 places no limit on the number of polls.
- R9: `done` is high for exactly one cycle per command. `err` is only ever high together with `done`.
- R10: A `start` pulse that arrives while a command is in progress is ignored. It does not change the bytes written or the order of accesses.
- R11: During reset and after it, with no `start`, there is no bus access and `done` and `err` stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one command when idle |
| cmd_word | input | 32 | Command word, captured on `start` |
| poll_limit | input | 16 | Maximum number of busy reads that may return 1; 0 means unlimited |
| done | output | 1 | One-cycle pulse at the end of each command |
| err | output | 1 | High with `done` when the command failed |
| bus_addr | output | 8 | Byte address of the current access |
| bus_write | output | 1 | Write strobe |
| bus_read | output | 1 | Read strobe |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid the cycle after a read is accepted |
| bus_waitreq | input | 1 | Stall: holds the current access while high |

## Verification
The bound checker watches the bus rules on every cycle:
- a read and a write are never presented together;
- a stalled access stays stable;
- the launch and clear writes carry the right values;
- `done` is a single-cycle pulse, and `err` appears only alongside it.

Some behaviour only the bench scenarios can show. These are the full access order, the byte order of the command word, and the branch taken on the acknowledge and busy values. They also include the poll limit, the timing of read-data sampling and the rejection of a second `start`. The bench shows these by comparing each accepted access against a queue built from the requirements. It also compares the `done` and `err` cycle against the latency of the final access.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    // Mailbox register map; the order of accesses is fixed by the handshake.
    localparam logic [7:0] MB_DATA_BASE = 8'h84;
    localparam logic [7:0] MB_LAUNCH    = 8'h90;
    localparam logic [7:0] MB_ACK       = 8'h8A;
    localparam logic [7:0] MB_BUSY      = 8'h8B;
    localparam int         ACK_BIT      = 7;
    localparam int         BUSY_BIT     = 0;
    localparam logic [7:0] LAUNCH_VAL   = 8'h01;
    localparam logic [7:0] ACK_CLR_VAL  = 8'h80;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_DATA,
        SQ_TRIG,
        SQ_ACK,
        SQ_POLL,
        SQ_CLEAR
    } seq_state_e;

    typedef enum logic [1:0] {
        BP_IDLE,
        BP_ISSUE,
        BP_CAPT
    } port_state_e;

endpackage

// File: rtl/mbox_bus_port.sv
module mbox_bus_port
    import mbox_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              acc_done,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_write,
    output logic              bus_read,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_waitreq
);

    typedef struct packed {
        port_state_e       st;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              done;
    } port_t;

    port_t p_d, p_q;

    always_comb begin
        p_d      = p_q;
        p_d.done = 1'b0;
        case (p_q.st)
            BP_IDLE: begin
                if (req) begin
                    p_d.st    = BP_ISSUE;
                    p_d.we    = req_we;
                    p_d.addr  = req_addr;
                    p_d.wdata = req_wdata;
                end
            end
            BP_ISSUE: begin
                if (!bus_waitreq) begin
                    if (p_q.we) begin
                        p_d.st   = BP_IDLE;
                        p_d.done = 1'b1;
                    end else begin
                        p_d.st = BP_CAPT;
                    end
                end
            end
            BP_CAPT: begin
                // read data is valid the cycle after acceptance
                p_d.rdata = bus_rdata;
                p_d.done  = 1'b1;
                p_d.st    = BP_IDLE;
            end
            default: p_d.st = BP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q <= '{st: BP_IDLE, we: 1'b0, addr: '0, wdata: '0, rdata: '0, done: 1'b0};
        end else begin
            p_q <= p_d;
        end
    end

    assign bus_addr  = p_q.addr;
    assign bus_wdata = p_q.wdata;
    assign bus_write = (p_q.st == BP_ISSUE) &&  p_q.we;
    assign bus_read  = (p_q.st == BP_ISSUE) && !p_q.we;
    assign acc_done  = p_q.done;
    assign rd_data   = p_q.rdata;

endmodule

// File: rtl/mbox_poll_timer.sv
module mbox_poll_timer #(
    parameter int POLL_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              inc,
    input  logic [POLL_W-1:0] limit,
    output logic              at_limit
);

    localparam int EXT_W = POLL_W + 1;

    logic [POLL_W-1:0] cnt_d, cnt_q;
    logic [EXT_W-1:0]  cnt_next;

    assign cnt_next = {1'b0, cnt_q} + EXT_W'(1);

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc) begin
            cnt_d = cnt_next[POLL_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // true when one more busy read would reach the programmed limit
    assign at_limit = (limit != '0) && (cnt_next == {1'b0, limit});

endmodule

// File: rtl/mbox_cmd_seq.sv
module mbox_cmd_seq
    import mbox_pkg::*;
#(
    parameter int CMD_W  = 32,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8,
    parameter int POLL_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CMD_W-1:0]  cmd_word,
    input  logic [POLL_W-1:0] poll_limit,
    output logic              done,
    output logic              err,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_write,
    output logic              bus_read,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_waitreq
);

    localparam int NBYTES = CMD_W / DATA_W;
    localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NBYTES - 1);

    typedef struct packed {
        seq_state_e        state;
        logic [IDX_W-1:0]  idx;
        logic              issued;
        logic [CMD_W-1:0]  cmd;
        logic              done;
        logic              err;
    } seq_t;

    seq_t s_d, s_q;

    logic              req;
    logic              req_we;
    logic [ADDR_W-1:0] req_addr;
    logic [DATA_W-1:0] req_wdata;
    logic              acc_done;
    logic [DATA_W-1:0] rd_data;
    logic              tmr_clr;
    logic              tmr_inc;
    logic              tmr_last;
    logic [CMD_W-1:0]  cmd_shifted;

    assign cmd_shifted = s_q.cmd >> (DATA_W * int'(s_q.idx));

    // request decode: one access per state, issued once
    always_comb begin
        req       = (s_q.state != SQ_IDLE) && !s_q.issued;
        req_we    = 1'b1;
        req_addr  = '0;
        req_wdata = '0;
        case (s_q.state)
            SQ_DATA: begin
                req_addr  = ADDR_W'(MB_DATA_BASE) + ADDR_W'(s_q.idx);
                req_wdata = cmd_shifted[DATA_W-1:0];
            end
            SQ_TRIG: begin
                req_addr  = ADDR_W'(MB_LAUNCH);
                req_wdata = DATA_W'(LAUNCH_VAL);
            end
            SQ_ACK: begin
                req_we   = 1'b0;
                req_addr = ADDR_W'(MB_ACK);
            end
            SQ_POLL: begin
                req_we   = 1'b0;
                req_addr = ADDR_W'(MB_BUSY);
            end
            SQ_CLEAR: begin
                req_addr  = ADDR_W'(MB_ACK);
                req_wdata = DATA_W'(ACK_CLR_VAL);
            end
            default: ;
        endcase
    end

    // sequencing
    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.err  = 1'b0;
        tmr_clr  = 1'b0;
        tmr_inc  = 1'b0;
        if (req) begin
            s_d.issued = 1'b1;
        end
        case (s_q.state)
            SQ_IDLE: begin
                if (start) begin
                    s_d.state  = SQ_DATA;
                    s_d.cmd    = cmd_word;
                    s_d.idx    = '0;
                    s_d.issued = 1'b0;
                    tmr_clr    = 1'b1;
                end
            end
            SQ_DATA: begin
                if (acc_done) begin
                    s_d.issued = 1'b0;
                    if (s_q.idx == LAST_IDX) begin
                        s_d.state = SQ_TRIG;
                    end else begin
                        s_d.idx = s_q.idx + IDX_W'(1);
                    end
                end
            end
            SQ_TRIG: begin
                if (acc_done) begin
                    s_d.issued = 1'b0;
                    s_d.state  = SQ_ACK;
                end
            end
            SQ_ACK: begin
                if (acc_done) begin
                    s_d.issued = 1'b0;
                    if (rd_data[ACK_BIT]) begin
                        s_d.state = SQ_POLL;
                    end else begin
                        s_d.state = SQ_IDLE;
                        s_d.done  = 1'b1;
                        s_d.err   = 1'b1;
                    end
                end
            end
            SQ_POLL: begin
                if (acc_done) begin
                    s_d.issued = 1'b0;
                    if (!rd_data[BUSY_BIT]) begin
                        s_d.state = SQ_CLEAR;
                    end else if (tmr_last) begin
                        s_d.state = SQ_IDLE;
                        s_d.done  = 1'b1;
                        s_d.err   = 1'b1;
                    end else begin
                        tmr_inc = 1'b1;
                    end
                end
            end
            SQ_CLEAR: begin
                if (acc_done) begin
                    s_d.issued = 1'b0;
                    s_d.state  = SQ_IDLE;
                    s_d.done   = 1'b1;
                end
            end
            default: s_d.state = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{state: SQ_IDLE, idx: '0, issued: 1'b0, cmd: '0, done: 1'b0, err: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    mbox_bus_port #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .req_we     (req_we),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .acc_done   (acc_done),
        .rd_data    (rd_data),
        .bus_addr   (bus_addr),
        .bus_write  (bus_write),
        .bus_read   (bus_read),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_waitreq(bus_waitreq)
    );

    mbox_poll_timer #(
        .POLL_W(POLL_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmr_clr),
        .inc     (tmr_inc),
        .limit   (poll_limit),
        .at_limit(tmr_last)
    );

    assign done = s_q.done;
    assign err  = s_q.err;

endmodule

// File: rtl/mbox_cmd_seq_chk.sv
module mbox_cmd_seq_chk
    import mbox_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done,
    input logic              err,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_write,
    input logic              bus_read,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_waitreq
);

    p_one_access_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_write && bus_read));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_write || bus_read) && bus_waitreq |=>
            $stable(bus_addr) && $stable(bus_write) && $stable(bus_read) && $stable(bus_wdata));

    p_launch_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_write && (bus_addr == ADDR_W'(MB_LAUNCH)) |-> bus_wdata == DATA_W'(LAUNCH_VAL));

    p_clear_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_write && (bus_addr == ADDR_W'(MB_ACK)) |-> bus_wdata == DATA_W'(ACK_CLR_VAL));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_err_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

endmodule

bind mbox_cmd_seq mbox_cmd_seq_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .done       (done),
    .err        (err),
    .bus_addr   (bus_addr),
    .bus_write  (bus_write),
    .bus_read   (bus_read),
    .bus_wdata  (bus_wdata),
    .bus_waitreq(bus_waitreq)
);

// File: tb/mbox_cmd_seq_test.sv
`timescale 1ns/1ps
module mbox_cmd_seq_test;

    typedef struct {
        bit    we;
        int    addr;
        int    data;
        bit    last;
        bit    err;
        string tag;
    } acc_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] cmd_word = '0;
    logic [15:0] poll_limit = '0;
    logic        done;
    logic        err;
    logic [7:0]  bus_addr;
    logic        bus_write;
    logic        bus_read;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata = 8'h7E;
    logic        bus_waitreq = 1'b0;

    int   n_checks = 0;
    int   n_errors = 0;
    int   cyc = 0;
    int   done_at = -10;
    bit   exp_err = 0;
    bit   done_seen = 0;
    bit   slv_ack_ok = 1;
    int   slv_busy_left = 0;
    bit   wmode = 0;
    acc_t exp_q[$];

    always #2.5 clk = ~clk;

    mbox_cmd_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_word(cmd_word),
        .poll_limit(poll_limit), .done(done), .err(err),
        .bus_addr(bus_addr), .bus_write(bus_write), .bus_read(bus_read),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_waitreq(bus_waitreq)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", tag, act, expv, cyc);
        end
    endtask

    // Reference model: slave responses, access order and done timing, every cycle
    initial begin
        bit   pend;
        logic [7:0] pend_val;
        forever begin
            @(negedge clk);
            cyc++;
            pend = 0;
            pend_val = 8'h7E;
            if (rst_n) begin
                bit exp_done;
                exp_done = (cyc == done_at);
                check(done == exp_done, "R9 done timing", int'(done), int'(exp_done));
                check(err == (exp_done && exp_err), "R9 err with done", int'(err), int'(exp_done && exp_err));
                if (done) done_seen = 1;
                if ((bus_write || bus_read) && !bus_waitreq) begin
                    if (exp_q.size() == 0) begin
                        check(0, "R10/R11 unexpected access", int'(bus_addr), 0);
                    end else begin
                        acc_t e;
                        e = exp_q.pop_front();
                        check(bus_write == e.we, {e.tag, " direction"}, int'(bus_write), int'(e.we));
                        check(int'(bus_addr) == e.addr, {e.tag, " address"}, int'(bus_addr), e.addr);
                        if (e.we)
                            check(int'(bus_wdata) == e.data, {e.tag, " write data"}, int'(bus_wdata), e.data);
                        if (e.last) begin
                            done_at = cyc + (e.we ? 2 : 3);
                            exp_err = e.err;
                        end
                    end
                    if (bus_read) begin
                        pend = 1;
                        if (bus_addr == 8'h8A) begin
                            pend_val = slv_ack_ok ? 8'h85 : 8'h05;
                        end else if (slv_busy_left > 0) begin
                            pend_val = 8'h41;
                            slv_busy_left--;
                        end else begin
                            pend_val = 8'h40;
                        end
                    end
                end
            end
            @(posedge clk);
            #1;
            // R7: real data only in the cycle after acceptance
            bus_rdata   = pend ? pend_val : 8'h7E;
            bus_waitreq = wmode && ((cyc % 3) != 0);
        end
    end

    task automatic push(input bit we, input int addr, input int data, input bit last,
                        input bit e, input string tag);
        acc_t a;
        a.we = we; a.addr = addr; a.data = data; a.last = last; a.err = e; a.tag = tag;
        exp_q.push_back(a);
    endtask

    task automatic run_cmd(input logic [31:0] word, input bit ack_ok, input int nbusy,
                           input int limit, input bit wm, input bit extra_start);
        int nreads;
        bit tmo;
        slv_ack_ok    = ack_ok;
        slv_busy_left = nbusy;
        wmode         = wm;
        done_seen     = 0;
        done_at       = -10;
        for (int i = 0; i < 4; i++) push(1, 'h84 + i, int'(word[8*i +: 8]), 0, 0, "R1");
        push(1, 'h90, 'h01, 0, 0, "R2");
        push(0, 'h8A, 0, !ack_ok, 1, "R3");
        if (ack_ok) begin
            tmo    = (limit != 0) && (nbusy >= limit);
            nreads = tmo ? limit : nbusy + 1;
            for (int i = 0; i < nreads; i++)
                push(0, 'h8B, 0, tmo && (i == nreads - 1), 1, tmo ? "R8" : "R4");
            if (!tmo) push(1, 'h8A, 'h80, 1, 0, "R5");
        end
        @(posedge clk); #1;
        cmd_word   = word;
        poll_limit = 16'(limit);
        start      = 1'b1;
        @(posedge clk); #1;
        start      = 1'b0;
        if (extra_start) begin
            repeat (6) @(posedge clk);
            #1;
            cmd_word = ~word;
            start    = 1'b1;
            @(posedge clk); #1;
            start    = 1'b0;
        end
        for (int w = 0; w < 2000 && !done_seen; w++) @(negedge clk);
        check(done_seen, "R9 command completed", int'(done_seen), 1);
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, extra_start ? "R10 access count" : "R4 access count",
              exp_q.size(), 0);
        exp_q.delete();
    endtask

    // watchdog
    initial begin
        repeat (40000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(done == 1'b0 && err == 1'b0, "R11 outputs in reset", int'({done, err}), 0);
        check(!bus_write && !bus_read, "R11 bus idle in reset", int'({bus_write, bus_read}), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        repeat (8) @(negedge clk);
        check(!bus_write && !bus_read && !done, "R11 quiet after reset",
              int'({bus_write, bus_read, done}), 0);

        run_cmd(32'h03CC1933, 1, 0, 0, 0, 0);  // R1 R2 R5 basic
        run_cmd(32'hDEADBEEF, 1, 3, 0, 1, 0);  // R4 R6 R7 stalls and polling
        run_cmd(32'h12345678, 0, 0, 0, 1, 0);  // R3 missing acknowledge
        run_cmd(32'hA5A55A5A, 1, 2, 3, 0, 0);  // R8 limit not reached
        run_cmd(32'h0F0F00FF, 1, 5, 3, 1, 0);  // R8 timeout
        run_cmd(32'h89ABCDEF, 1, 4, 0, 1, 1);  // R10 second start ignored
        run_cmd(32'h00000001, 1, 0, 1, 0, 0);  // R8 limit of one, idle at first poll
        run_cmd(32'hFFFFFFFF, 1, 7, 0, 0, 0);  // R8 zero limit is unlimited

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule